// File: doc/BRIEF.md
# DRAM Refresh Sequencer

The sequencer keeps a 64-row dynamic memory array alive by slipping refresh cycles into gaps in the processor's memory timing. It watches a transfer-timing strobe and treats each rising edge of that strobe as the start of the strobe's second portion. While the processor runs, every second strobe edge that falls on an instruction fetch is a refresh opportunity. While the processor is halted, every eighth strobe edge is one. A write cycle on the opportune edge cancels the refresh, so the processor's own address stays on the bus for the write.

An accepted refresh raises a busy flag. A clock-cycle counter then waits out a fixed delay, about 270 ns rounded up to whole clocks, before pulling the active-low row select down for a short strobe. During that strobe the refresh row number drives the shared 6-bit address bus. When the refresh ends, the internal row counter moves on to the next row, wrapping from 63 to 0. Outside a refresh, the bus carries the processor's row address, or its column address (memory-address bits 6 to 11) in the column phase. Every pin is a plain control or status level. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset, refresh_busy is 0 and row_sel_n is 1 while mem_sel is 0. The first refresh uses row 0.
- R2: While halted is 0, a strobe rising edge (xtc high at a clock edge after being low at the previous edge) with ifetch high counts one fetch. Every second counted fetch (the 2nd, 4th and so on after reset) starts a refresh, and refresh_busy rises after that clock edge. A rising edge with ifetch low is not counted.
- R3: While halted is 1, every eighth strobe rising edge starts a refresh, whatever ifetch is.
- R4: If wr_cycle is high at a rising edge that would start a refresh, no refresh starts and the address bus keeps the processor address. The fetch and halt counts still advance.
- R5: row_sel_n goes low exactly DELAY_CYC clocks after the edge that starts a refresh, where DELAY_CYC = ceil(DELAY_PS / CLK_PERIOD_PS) (27 with the defaults). It stays low for PULSE_CYC clocks (4). refresh_busy falls together with the end of that strobe.
- R6: While refresh_busy is 1, addr equals the refresh row and addr_src is 2, whatever mem_sel is.
- R7: Each completed refresh advances the refresh row by one, wrapping from 63 to 0.
- R8: While refresh_busy is 0, addr_src is 1 and addr is cpu_col when mem_sel and col_phase are both 1. Otherwise addr_src is 0 and addr is cpu_row. row_sel_n is low exactly when mem_sel is 1.
- R9: A rising edge that falls while a refresh is in progress never starts a second refresh, although it still advances the counts.
- R10: Under continuous fetching, all 64 rows are refreshed well within a budget of 2 ms worth of clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtc | input | 1 | Transfer-timing strobe; a rising edge opens its second portion |
| ifetch | input | 1 | Current cycle is an instruction fetch |
| halted | input | 1 | Processor is halted |
| wr_cycle | input | 1 | Second strobe portion is a write |
| mem_sel | input | 1 | Processor memory access in progress |
| col_phase | input | 1 | Processor access is in its column phase |
| cpu_row | input | 6 | Processor row address |
| cpu_col | input | 6 | Processor column address (memory-address bits 6 to 11) |
| addr | output | 6 | Multiplexed memory address bus |
| row_sel_n | output | 1 | Active-low row select |
| addr_src | output | 2 | Address source: 0 processor row, 1 processor column, 2 refresh row |
| refresh_busy | output | 1 | Refresh cycle in progress |

## Verification
Two kinds of collision are provoked on purpose. In the first, a write cycle lands on exactly the strobe edge that would start a refresh, and the bench judges that no refresh begins and that the fetch count has still moved on, because the next pair of fetches starts a refresh on its second fetch. In the second, a processor access (mem_sel high in the column phase) overlaps a refresh, and strobe edges keep arriving while the refresh is busy. The bench checks every clock that the refresh row owns the bus and that the overlapping edges are dropped rather than queued.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  typedef enum logic [1:0] {
    SRC_CPU_ROW = 2'd0,
    SRC_CPU_COL = 2'd1,
    SRC_REFRESH = 2'd2
  } addr_src_e;
endpackage

// File: rtl/refresh_trigger.sv
module refresh_trigger #(
  parameter int FETCH_DIV = 2,
  parameter int HALT_DIV  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xtc,
  input  logic ifetch,
  input  logic halted,
  input  logic wr_cycle,
  input  logic busy,
  output logic start
);
  localparam int FW = (FETCH_DIV > 1) ? $clog2(FETCH_DIV) : 1;
  localparam int HW = (HALT_DIV > 1) ? $clog2(HALT_DIV) : 1;

  logic          xtc_q;
  logic [FW-1:0] fetch_cnt;
  logic [HW-1:0] halt_cnt;
  logic          rise;
  logic          fetch_hit;
  logic          halt_hit;

  assign rise      = xtc & ~xtc_q;
  assign fetch_hit = rise & ~halted & ifetch & (fetch_cnt == FW'(FETCH_DIV - 1));
  assign halt_hit  = rise & halted & (halt_cnt == HW'(HALT_DIV - 1));
  assign start     = (fetch_hit | halt_hit) & ~wr_cycle & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xtc_q     <= 1'b0;
      fetch_cnt <= '0;
      halt_cnt  <= '0;
    end else begin
      xtc_q <= xtc;
      if (rise && !halted && ifetch) begin
        if (fetch_cnt == FW'(FETCH_DIV - 1)) fetch_cnt <= '0;
        else                                 fetch_cnt <= fetch_cnt + 1'b1;
      end
      if (rise && halted) begin
        if (halt_cnt == HW'(HALT_DIV - 1)) halt_cnt <= '0;
        else                               halt_cnt <= halt_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int DELAY_CYC = 27,
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic strobe,
  output logic done
);
  localparam int TOTAL = DELAY_CYC + PULSE_CYC;
  localparam int CW    = (TOTAL > 1) ? $clog2(TOTAL) : 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = busy_q && (cnt_q == CW'(TOTAL - 1));
  assign busy   = busy_q;
  assign strobe = busy_q && (cnt_q >= CW'(DELAY_CYC));
  assign done   = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end
endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   row <= '0;
    else if (inc) row <= row + 1'b1;
  end
endmodule

// File: rtl/refresh_addr_mux.sv
module refresh_addr_mux
  import dram_refresh_pkg::*;
#(
  parameter int ROW_W = 6
) (
  input  logic             busy,
  input  logic             strobe,
  input  logic             mem_sel,
  input  logic             col_phase,
  input  logic [ROW_W-1:0] ref_row,
  input  logic [ROW_W-1:0] cpu_row,
  input  logic [ROW_W-1:0] cpu_col,
  output logic [ROW_W-1:0] addr,
  output logic [1:0]       addr_src,
  output logic             row_sel_n
);
  addr_src_e src;

  always_comb begin
    if (busy)                       src = SRC_REFRESH;
    else if (mem_sel && col_phase)  src = SRC_CPU_COL;
    else                            src = SRC_CPU_ROW;
  end

  always_comb begin
    unique case (src)
      SRC_REFRESH: addr = ref_row;
      SRC_CPU_COL: addr = cpu_col;
      default:     addr = cpu_row;
    endcase
  end

  assign addr_src  = src;
  assign row_sel_n = busy ? ~strobe : ~mem_sel;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int ROW_W         = 6,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int DELAY_PS      = 270000,
  parameter int PULSE_CYC     = 4,
  parameter int FETCH_DIV     = 2,
  parameter int HALT_DIV      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtc,
  input  logic             ifetch,
  input  logic             halted,
  input  logic             wr_cycle,
  input  logic             mem_sel,
  input  logic             col_phase,
  input  logic [ROW_W-1:0] cpu_row,
  input  logic [ROW_W-1:0] cpu_col,
  output logic [ROW_W-1:0] addr,
  output logic             row_sel_n,
  output logic [1:0]       addr_src,
  output logic             refresh_busy
);
  localparam int DELAY_CYC = (DELAY_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

  logic             start;
  logic             busy_int;
  logic             strobe;
  logic             done;
  logic [ROW_W-1:0] ref_row;

  refresh_trigger #(.FETCH_DIV(FETCH_DIV), .HALT_DIV(HALT_DIV)) u_trigger (
    .clk(clk), .rst_n(rst_n), .xtc(xtc), .ifetch(ifetch), .halted(halted),
    .wr_cycle(wr_cycle), .busy(busy_int), .start(start)
  );

  refresh_timer #(.DELAY_CYC(DELAY_CYC), .PULSE_CYC(PULSE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy_int), .strobe(strobe), .done(done)
  );

  refresh_row_counter #(.ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .inc(done), .row(ref_row)
  );

  refresh_addr_mux #(.ROW_W(ROW_W)) u_mux (
    .busy(busy_int), .strobe(strobe), .mem_sel(mem_sel), .col_phase(col_phase),
    .ref_row(ref_row), .cpu_row(cpu_row), .cpu_col(cpu_col),
    .addr(addr), .addr_src(addr_src), .row_sel_n(row_sel_n)
  );

  assign refresh_busy = busy_int;
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int ROW_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xtc,
  input logic             wr_cycle,
  input logic             mem_sel,
  input logic             busy,
  input logic             row_sel_n,
  input logic [ROW_W-1:0] addr,
  input logic [1:0]       addr_src,
  input logic [ROW_W-1:0] ref_row
);
  logic xtc_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xtc_d <= 1'b0;
    else        xtc_d <= xtc;
  end

  // R1
  idle_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !mem_sel) |-> row_sel_n);

  // R4
  write_blocks_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xtc && !xtc_d && wr_cycle && !busy) |=> !busy);

  // R5
  strobe_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !row_sel_n) |-> $past(busy));

  // R6
  refresh_owns_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (addr_src == 2'd2 && addr == ref_row));

  // R7
  row_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ref_row == ROW_W'($past(ref_row) + 1'b1));

  // R8
  cpu_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mem_sel) |-> !row_sel_n);
endmodule

bind dram_refresh_seq dram_refresh_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xtc(xtc), .wr_cycle(wr_cycle), .mem_sel(mem_sel),
  .busy(refresh_busy), .row_sel_n(row_sel_n), .addr(addr), .addr_src(addr_src),
  .ref_row(ref_row)
);

// File: tb/dram_refresh_seq_bench.sv
`timescale 1ns/1ps
module dram_refresh_seq_bench;
  localparam int D      = 27;
  localparam int P      = 4;
  localparam int BUDGET = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtc = 0, ifetch = 0, halted = 0, wr_cycle = 0, mem_sel = 0, col_phase = 0;
  logic [5:0] cpu_row = 6'h15, cpu_col = 6'h2a;
  logic [5:0] addr;
  logic row_sel_n, refresh_busy;
  logic [1:0] addr_src;

  int checks = 0, fails = 0, cycles = 0, nref = 0;
  int m_xq = 0, m_f = 0, m_h = 0, m_busy = 0, m_t = 0, m_row = 0;
  bit busy_prev = 0, strobe_prev = 0, have_last = 0;
  int last_addr = 0;

  always #5 clk = ~clk;

  dram_refresh_seq u_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .xtc(xtc), .ifetch(ifetch), .halted(halted),
    .wr_cycle(wr_cycle), .mem_sel(mem_sel), .col_phase(col_phase),
    .cpu_row(cpu_row), .cpu_col(cpu_col), .addr(addr), .row_sel_n(row_sel_n),
    .addr_src(addr_src), .refresh_busy(refresh_busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced on each rising clock edge
  always @(posedge clk) begin
    int rise, hit, old_busy;
    if (!rst_n) begin
      m_xq = 0; m_f = 0; m_h = 0; m_busy = 0; m_t = 0; m_row = 0;
    end else begin
      rise = (xtc && !m_xq); m_xq = xtc; hit = 0; old_busy = m_busy;
      if (rise && halted) begin m_h = (m_h + 1) % 8; hit = (m_h == 0); end
      else if (rise && ifetch) begin m_f = (m_f + 1) % 2; hit = (m_f == 0); end
      if (old_busy) begin
        m_t++;
        if (m_t == D + P) begin m_busy = 0; m_row = (m_row + 1) % 64; end
      end else if (hit && !wr_cycle) begin
        m_busy = 1; m_t = 0;
      end
    end
  end

  // per-clock comparison away from the edge
  always @(negedge clk) begin
    int e_addr, e_src, e_rsn;
    bit strobe_now;
    cycles++;
    if (cycles > 190000) begin
      check(0, "watchdog", cycles, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (rst_n) begin
      if (m_busy) begin
        e_addr = m_row; e_src = 2; e_rsn = (m_t >= D) ? 0 : 1;
      end else begin
        e_src = (mem_sel && col_phase) ? 1 : 0;
        e_addr = e_src == 1 ? cpu_col : cpu_row;
        e_rsn = mem_sel ? 0 : 1;
      end
      check(refresh_busy == m_busy, "R2 busy", refresh_busy, m_busy);
      check(row_sel_n == e_rsn, "R5 row_sel_n", row_sel_n, e_rsn);
      check(addr == e_addr && addr_src == e_src, m_busy ? "R6 addr" : "R8 addr",
            {addr_src, addr}, {e_src[1:0], e_addr[5:0]});
      if (refresh_busy && !busy_prev) nref++;
      strobe_now = refresh_busy && !row_sel_n;
      if (strobe_now && !strobe_prev) begin
        if (have_last) check(addr == (last_addr + 1) % 64, "R7 next row", addr, (last_addr + 1) % 64);
        else check(addr == 0, "R1 first row", addr, 0);
        have_last = 1; last_addr = addr;
      end
      strobe_prev = strobe_now; busy_prev = refresh_busy;
    end
  end

  task automatic pulse(input bit f, input bit w, input int hi, input int lo);
    @(posedge clk); #2; xtc = 1; ifetch = f; wr_cycle = w;
    repeat (hi - 1) @(posedge clk);
    #2; xtc = 0; ifetch = 0; wr_cycle = 0;
    repeat (lo - 1) @(posedge clk);
  endtask

  task automatic settle();
    repeat (40) @(posedge clk);
  endtask

  initial begin
    int n0, c0;
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    @(negedge clk);
    check(refresh_busy == 0 && row_sel_n == 1 && addr_src == 0, "R1 reset",
          {refresh_busy, row_sel_n, addr_src}, 3'b010);

    n0 = nref; repeat (6) pulse(1, 0, 20, 20); settle();
    check(nref - n0 == 3, "R2 fetch pairs", nref - n0, 3);

    n0 = nref; repeat (4) pulse(0, 0, 20, 20); settle();
    check(nref - n0 == 0, "R2 no fetch", nref - n0, 0);

    @(posedge clk); #2; halted = 1;
    n0 = nref; repeat (16) pulse(0, 0, 20, 20); settle();
    check(nref - n0 == 2, "R3 halted eighth", nref - n0, 2);
    @(posedge clk); #2; halted = 0;

    n0 = nref; pulse(1, 0, 20, 20); pulse(1, 1, 20, 20); settle();
    check(nref - n0 == 0, "R4 write suppress", nref - n0, 0);
    n0 = nref; pulse(1, 0, 20, 20); pulse(1, 0, 20, 20); settle();
    check(nref - n0 == 1, "R4 count advanced", nref - n0, 1);

    n0 = nref; repeat (8) pulse(1, 0, 4, 4); settle();
    check(nref - n0 == 2, "R9 busy drops edges", nref - n0, 2);

    @(posedge clk); #2; mem_sel = 1; col_phase = 1; cpu_col = 6'h33;
    @(negedge clk);
    check(addr == 6'h33 && addr_src == 1 && row_sel_n == 0, "R8 column", addr, 6'h33);
    @(posedge clk); #2; col_phase = 0; cpu_row = 6'h0c;
    @(negedge clk);
    check(addr == 6'h0c && addr_src == 0, "R8 row", addr, 6'h0c);
    @(posedge clk); #2; col_phase = 1;
    n0 = nref; pulse(1, 0, 20, 20); pulse(1, 0, 20, 20); settle();
    check(nref - n0 == 1, "R6 refresh under access", nref - n0, 1);
    @(posedge clk); #2; mem_sel = 0; col_phase = 0;

    n0 = nref; c0 = cycles;
    while (nref - n0 < 64) pulse(1, 0, 20, 20);
    settle();
    check(cycles - c0 <= BUDGET, "R10 sweep budget", cycles - c0, BUDGET);
    check(have_last, "R7 strobes seen", have_last, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule